// File: doc/BRIEF.md
# Set-Associative Translation Lookup Unit

This block turns a 32-bit virtual address into a physical address by looking it up in a four-way set-associative translation table with 8 KB pages. Two independent tables are kept: one serves instruction fetches (execute accesses) and the other serves loads and stores. Each table has 16 slots per way, and each entry is a pair of 32-bit words. The first word carries the page tag and an owner tag. The second carries the physical frame and five attribute flags: global, valid, kernel-only, writable and executable. Software fills the tables through a one-entry write port.

A request carries the address, the access kind, a user-mode flag, a debug flag, the current 8-bit owner tag and a configuration word. The configuration word enables four protection checks. One cycle after the request strobe, the block returns a hit flag, the physical address, a three-bit permission set and a fault vector number. Any miss that is not marked debug also loads two registers that a refill handler reads: a select register that names the slot and way to fill, and a cause register. On a miss where no entry matched, the way is picked by a 16-bit LFSR that advances once per such miss.

Top module: `tlb_lookup_unit`

## Requirements
- R1: The slot is vaddr[16:13], the same in every way. An entry hits when hi[31:13] equals vaddr[31:13] and either lo[4] (global) is set or hi[7:0] equals the request's owner tag.
- R2: When several ways hit, the entry in the lowest-numbered way is used.
- R3: Access kind 2 (execute) looks only in the instruction table, with vector base 4. Kinds 0 (read), 1 (write) and 3 (treated as read) look only in the data table, with vector base 8. A miss with no matching entry returns the base vector.
- R4: A matching entry is turned into a miss by the first of these checks that applies, taken in this order. (a) cfg[18], lo[2] and user mode give base+2. (b) A write with cfg[19] set and lo[1] clear gives base+3. (c) An execute with cfg[17] set and lo[0] clear gives base+3. (d) cfg[16] set with lo[3] clear gives base+1.
- R5: On a successful lookup, prot[0] (read) is 1 and prot[1] (write) equals lo[1]. prot[2] (execute) is 1 only for execute accesses when cfg[17] or lo[0] is set. The physical address is {lo[31:13], vaddr[12:0]}. On any miss, prot and the physical address are 0.
- R6: On a non-debug miss, the select register becomes zero except for the slot in bits 3:0 and the way in bits 5:4. The way is the matching way for a protection fault, and LFSR bits 1:0 (the value before stepping) for a miss where no entry matched.
- R7: On a non-debug miss, the cause register is loaded with vaddr[31:13] in bits 31:13, the access code in bits 9:8 (execute 0, read 1, write 2) and the owner tag in bits 7:0. All its other bits are 0.
- R8: The LFSR resets to 0xCCCC. On every non-debug miss it shifts right by one, and the new bit 15 is the XOR of the state bits selected by mask 0x8805.
- R9: A miss with the debug flag set leaves the select register, the cause register and the LFSR unchanged.
- R10: The response valid flag rises exactly one cycle after the request strobe, and the outputs are held until the next request. A table write becomes visible to lookups from the next cycle on, so a lookup made in the same cycle as the write sees the old entry.
- R11: After reset, the response valid flag, the select register and the cause register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access made in user mode |
| req_debug | input | 1 | Probe-only lookup, no state update on miss |
| req_pid | input | 8 | Current owner tag |
| req_cfg | input | 32 | Protection enables in bits 19:16 |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | 0 instruction table, 1 data table |
| wr_way | input | 2 | Way to write |
| wr_slot | input | 4 | Slot to write |
| wr_hi | input | 32 | Tag word |
| wr_lo | input | 32 | Frame and flags word |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_prot | output | 3 | {execute, write, read} permission |
| rsp_vector | output | 4 | Fault vector number |
| sel_reg | output | 32 | Refill slot and way |
| cause_reg | output | 32 | Fault cause |

## Verification
A corrupted table entry or a wrong way priority appears on the very next response as a wrong hit flag, frame or permission set. A wrong fault order appears as a vector that is off by one or two. The LFSR state is not visible directly. An error in its seed, taps or stepping (for example, stepping on a debug miss) shows up in the way field of the select register on the next refill miss, or within a few misses, because the bench models the sequence and checks the way after each miss. Any error in the cause and select fields is visible in the same cycle as the miss response.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  // flag positions in the frame word
  localparam int LO_X = 0;
  localparam int LO_W = 1;
  localparam int LO_K = 2;
  localparam int LO_V = 3;
  localparam int LO_G = 4;

  // enable positions in the configuration word
  localparam int CFG_V = 16;
  localparam int CFG_X = 17;
  localparam int CFG_K = 18;
  localparam int CFG_W = 19;

  localparam logic [1:0] CAUSE_EXEC  = 2'd0;
  localparam logic [1:0] CAUSE_READ  = 2'd1;
  localparam logic [1:0] CAUSE_WRITE = 2'd2;

  localparam logic [3:0] VEC_INSN = 4'd4;
  localparam logic [3:0] VEC_DATA = 4'd8;

  localparam logic [1:0] OFF_INVALID = 2'd1;
  localparam logic [1:0] OFF_KERNEL  = 2'd2;
  localparam logic [1:0] OFF_PERM    = 2'd3;
endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank #(
  parameter int WAYS  = 4,
  parameter int SLOTS = 16,
  parameter int W     = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [WAY_W-1:0]          wr_way,
  input  logic [SLOT_W-1:0]         wr_slot,
  input  logic [W-1:0]              wr_hi,
  input  logic [W-1:0]              wr_lo,
  input  logic [SLOT_W-1:0]         rd_slot,
  output logic [WAYS-1:0][W-1:0]    rd_hi,
  output logic [WAYS-1:0][W-1:0]    rd_lo
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [2*W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(g)) begin
        mem[wr_slot] <= {wr_hi, wr_lo};
      end
    end

    assign rd_hi[g] = mem[rd_slot][2*W-1:W];
    assign rd_lo[g] = mem[rd_slot][W-1:0];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_lookup_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int W      = 32,
  parameter int PAGE_W = 13,
  parameter int PID_W  = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int VPN_W = W - PAGE_W
) (
  input  logic [WAYS-1:0][W-1:0] hi,
  input  logic [WAYS-1:0][W-1:0] lo,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [PID_W-1:0]       pid,
  output logic                   found,
  output logic [WAY_W-1:0]       way,
  output logic [W-1:0]           hit_lo
);
  logic [WAYS-1:0] way_hit;
  logic            unused_hi_bits;

  always_comb begin
    unused_hi_bits = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = (hi[w][W-1:PAGE_W] == vpn) &&
                   (lo[w][LO_G] || hi[w][PID_W-1:0] == pid);
      unused_hi_bits = unused_hi_bits ^ (^hi[w][PAGE_W-1:PID_W]);
    end
  end

  // scan from the top so the lowest matching way is the last written
  always_comb begin
    found  = 1'b0;
    way    = '0;
    hit_lo = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        found  = 1'b1;
        way    = WAY_W'(w);
        hit_lo = lo[w];
      end
    end
  end
endmodule

// File: rtl/tlb_fault_prio.sv
module tlb_fault_prio
  import tlb_lookup_pkg::*;
(
  input  logic [3:0] flags,     // {valid, kernel, write, execute}
  input  logic [1:0] kind,
  input  logic       user,
  input  logic [3:0] cfg_en,    // {write, kernel, execute, valid} enables
  output logic       fault,
  output logic [1:0] vec_off
);
  logic f_x, f_w, f_k, f_v;
  logic e_v, e_x, e_k, e_w;

  assign {f_v, f_k, f_w, f_x} = flags;
  assign {e_w, e_k, e_x, e_v} = cfg_en;

  always_comb begin
    fault   = 1'b1;
    vec_off = 2'd0;
    if (e_k && f_k && user) begin
      vec_off = OFF_KERNEL;
    end else if (kind == ACC_WRITE && e_w && !f_w) begin
      vec_off = OFF_PERM;
    end else if (kind == ACC_EXEC && e_x && !f_x) begin
      vec_off = OFF_PERM;
    end else if (e_v && !f_v) begin
      vec_off = OFF_INVALID;
    end else begin
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr #(
  parameter int          LW   = 16,
  parameter logic [LW-1:0] SEED = 16'hCCCC,
  parameter logic [LW-1:0] TAPS = 16'h8805
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [LW-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (step) begin
      state <= {fb, state[LW-1:1]};
    end
  end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_lookup_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 13,
  parameter int WAYS   = 4,
  parameter int SLOTS  = 16,
  parameter int PID_W  = 8,
  parameter int LFSR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_user,
  input  logic                      req_debug,
  input  logic [PID_W-1:0]          req_pid,
  input  logic [VA_W-1:0]           req_cfg,
  input  logic                      wr_en,
  input  logic                      wr_side,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [$clog2(SLOTS)-1:0]  wr_slot,
  input  logic [VA_W-1:0]           wr_hi,
  input  logic [VA_W-1:0]           wr_lo,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [VA_W-1:0]           rsp_paddr,
  output logic [2:0]                rsp_prot,
  output logic [3:0]                rsp_vector,
  output logic [VA_W-1:0]           sel_reg,
  output logic [VA_W-1:0]           cause_reg
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int SIDES  = 2;

  logic [WAYS-1:0][VA_W-1:0] side_hi [SIDES];
  logic [WAYS-1:0][VA_W-1:0] side_lo [SIDES];
  logic [WAYS-1:0][VA_W-1:0] cur_hi, cur_lo;

  logic [VPN_W-1:0]  vpn;
  logic [SLOT_W-1:0] slot;
  logic              is_exec;

  assign vpn     = req_vaddr[VA_W-1:PAGE_W];
  assign slot    = vpn[SLOT_W-1:0];
  assign is_exec = (req_kind == ACC_EXEC);

  // side 0 holds instruction entries, side 1 data entries
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    tlb_entry_bank #(.WAYS(WAYS), .SLOTS(SLOTS), .W(VA_W)) bank_i (
      .clk     (clk),
      .wr_en   (wr_en && (wr_side == 1'(s))),
      .wr_way  (wr_way),
      .wr_slot (wr_slot),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .rd_slot (slot),
      .rd_hi   (side_hi[s]),
      .rd_lo   (side_lo[s])
    );
  end

  assign cur_hi = is_exec ? side_hi[0] : side_hi[1];
  assign cur_lo = is_exec ? side_lo[0] : side_lo[1];

  logic             found;
  logic [WAY_W-1:0] match_way;
  logic [VA_W-1:0]  hit_lo;

  tlb_way_match #(.WAYS(WAYS), .W(VA_W), .PAGE_W(PAGE_W), .PID_W(PID_W)) match_i (
    .hi     (cur_hi),
    .lo     (cur_lo),
    .vpn    (vpn),
    .pid    (req_pid),
    .found  (found),
    .way    (match_way),
    .hit_lo (hit_lo)
  );

  logic       fault;
  logic [1:0] vec_off;

  tlb_fault_prio fault_i (
    .flags   (hit_lo[LO_V:LO_X]),
    .kind    (req_kind),
    .user    (req_user),
    .cfg_en  (req_cfg[CFG_W:CFG_V]),
    .fault   (fault),
    .vec_off (vec_off)
  );

  logic [LFSR_W-1:0] lfsr_q;
  logic              miss_upd;

  tlb_victim_lfsr #(.LW(LFSR_W)) lfsr_i (
    .clk   (clk),
    .rst   (rst),
    .step  (miss_upd),
    .state (lfsr_q)
  );

  logic              ok;
  logic [3:0]        vec_n;
  logic [2:0]        prot_n;
  logic [VA_W-1:0]   paddr_n;
  logic [WAY_W-1:0]  fill_way;
  logic [VA_W-1:0]   sel_n, cause_n;
  logic [1:0]        code;
  logic              unused_bits;

  assign unused_bits = ^{req_cfg[VA_W-1:CFG_W+1], req_cfg[CFG_V-1:0],
                         hit_lo[PAGE_W-1:LO_G], lfsr_q[LFSR_W-1:WAY_W]};

  always_comb begin
    ok       = found && !fault;
    miss_upd = req_valid && !ok && !req_debug;
    vec_n    = (is_exec ? VEC_INSN : VEC_DATA) + {2'b00, found ? vec_off : 2'd0};
    prot_n   = '0;
    paddr_n  = '0;
    if (ok) begin
      prot_n[0] = 1'b1;
      prot_n[1] = hit_lo[LO_W];
      prot_n[2] = is_exec && (req_cfg[CFG_X] || hit_lo[LO_X]);
      paddr_n   = {hit_lo[VA_W-1:PAGE_W], req_vaddr[PAGE_W-1:0]};
    end
    fill_way = found ? match_way : lfsr_q[WAY_W-1:0];
    sel_n    = '0;
    sel_n[SLOT_W-1:0]            = slot;
    sel_n[SLOT_W+WAY_W-1:SLOT_W] = fill_way;
    case (req_kind)
      ACC_EXEC:  code = CAUSE_EXEC;
      ACC_WRITE: code = CAUSE_WRITE;
      default:   code = CAUSE_READ;
    endcase
    cause_n = '0;
    cause_n[VA_W-1:PAGE_W] = vpn;
    cause_n[9:8]           = code;
    cause_n[PID_W-1:0]     = req_pid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
      rsp_prot   <= '0;
      rsp_vector <= '0;
      sel_reg    <= '0;
      cause_reg  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= ok;
        rsp_paddr  <= paddr_n;
        rsp_prot   <= prot_n;
        rsp_vector <= vec_n;
      end
      if (miss_upd) begin
        sel_reg   <= sel_n;
        cause_reg <= cause_n;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int VA_W   = 32,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_debug,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [2:0]        rsp_prot,
  input logic [3:0]        rsp_vector,
  input logic [VA_W-1:0]   sel_reg,
  input logic [VA_W-1:0]   cause_reg,
  input logic [LFSR_W-1:0] lfsr_q
);
  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  a_r5_hit_reads: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> rsp_prot[0]);

  a_r5_miss_no_perm: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_prot == 3'b000));

  a_r3_vector_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_vector >= 4'd4 && rsp_vector <= 4'd11));

  a_r3_exec_insn_side: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_kind) == 2'd2) |-> (rsp_vector < 4'd8));

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  a_r9_debug_no_update: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && $past(req_debug))
      |-> ($stable(sel_reg) && $stable(cause_reg) && $stable(lfsr_q)));
endmodule

bind tlb_lookup_unit tlb_lookup_chk #(.VA_W(VA_W), .LFSR_W(LFSR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_debug  (req_debug),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_prot   (rsp_prot),
  .rsp_vector (rsp_vector),
  .sel_reg    (sel_reg),
  .cause_reg  (cause_reg),
  .lfsr_q     (lfsr_q)
);

// File: tb/tlb_lookup_unit_tb_top.sv
module tlb_lookup_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_user, req_debug;
  logic [31:0] req_vaddr, req_cfg;
  logic [1:0]  req_kind;
  logic [7:0]  req_pid;
  logic        wr_en, wr_side;
  logic [1:0]  wr_way;
  logic [3:0]  wr_slot;
  logic [31:0] wr_hi, wr_lo;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr, sel_reg, cause_reg;
  logic [2:0]  rsp_prot;
  logic [3:0]  rsp_vector;

  always #4 clk = ~clk;

  tlb_lookup_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .req_debug(req_debug),
    .req_pid(req_pid), .req_cfg(req_cfg), .wr_en(wr_en), .wr_side(wr_side),
    .wr_way(wr_way), .wr_slot(wr_slot), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_prot(rsp_prot), .rsp_vector(rsp_vector), .sel_reg(sel_reg),
    .cause_reg(cause_reg)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the tables and refill state
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [15:0] m_lfsr;
  logic [31:0] m_sel, m_cause;

  // write performed in the same cycle as the next lookup when set
  bit          pw_en = 1'b0;
  bit          pw_side;
  logic [1:0]  pw_way;
  logic [3:0]  pw_slot;
  logic [31:0] pw_hi, pw_lo;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] pid);
    return {vpn, 5'b0, pid};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input bit g, v, k, w, x);
    return {pfn, 8'b0, g, v, k, w, x};
  endfunction

  task automatic put(input bit side, input logic [1:0] way, input logic [3:0] slot,
                     input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_way = way; wr_slot = slot; wr_hi = hi; wr_lo = lo;
    @(negedge clk);
    wr_en = 1'b0;
    m_hi[side][way][slot] = hi;
    m_lo[side][way][slot] = lo;
  endtask

  // one lookup: model from the requirements, drive, sample one cycle later
  task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] kind,
                        input bit user, input bit dbg, input logic [7:0] pid,
                        input logic [31:0] cfg, input bit exp_hit, input logic [3:0] exp_vec);
    int side, slot, mway;
    bit fnd, ok;
    logic [31:0] lo, e_pa;
    logic [3:0]  base, e_vec;
    logic [2:0]  e_prot;
    logic [1:0]  code;
    side = (kind == 2'd2) ? 0 : 1;
    slot = va[16:13];
    base = (side == 0) ? 4'd4 : 4'd8;
    fnd = 1'b0; mway = 0; lo = '0;
    for (int w = 0; w < 4; w++) begin
      if (!fnd && m_hi[side][w][slot][31:13] == va[31:13] &&
          (m_lo[side][w][slot][4] || m_hi[side][w][slot][7:0] == pid)) begin
        fnd = 1'b1; mway = w; lo = m_lo[side][w][slot];
      end
    end
    e_vec = base; ok = fnd;
    if (fnd) begin
      if (cfg[18] && lo[2] && user) begin e_vec = base + 2; ok = 0; end
      else if (kind == 2'd1 && cfg[19] && !lo[1]) begin e_vec = base + 3; ok = 0; end
      else if (kind == 2'd2 && cfg[17] && !lo[0]) begin e_vec = base + 3; ok = 0; end
      else if (cfg[16] && !lo[3]) begin e_vec = base + 1; ok = 0; end
    end
    e_prot = ok ? {(side == 0) && (cfg[17] || lo[0]), lo[1], 1'b1} : 3'b000;
    e_pa   = ok ? {lo[31:13], va[12:0]} : 32'h0;
    if (!ok && !dbg) begin
      code    = (kind == 2'd2) ? 2'd0 : (kind == 2'd1) ? 2'd2 : 2'd1;
      m_sel   = {26'b0, fnd ? 2'(mway) : m_lfsr[1:0], 4'(slot)};
      m_cause = {va[31:13], 3'b0, code, pid};
      m_lfsr  = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
    end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
    req_debug = dbg; req_pid = pid; req_cfg = cfg;
    if (pw_en) begin
      wr_en = 1'b1; wr_side = pw_side; wr_way = pw_way; wr_slot = pw_slot;
      wr_hi = pw_hi; wr_lo = pw_lo;
    end
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    if (pw_en) begin
      m_hi[pw_side][pw_way][pw_slot] = pw_hi;
      m_lo[pw_side][pw_way][pw_slot] = pw_lo;
      pw_en = 1'b0;
    end
    check({tag, " R10 valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit(spec)"}, 32'(rsp_hit), 32'(exp_hit));
    check({tag, " hit(model)"}, 32'(rsp_hit), 32'(ok));
    check({tag, " vector(spec)"}, 32'(rsp_vector), 32'(exp_vec));
    check({tag, " vector(model)"}, 32'(rsp_vector), 32'(e_vec));
    check({tag, " R5 prot"}, 32'(rsp_prot), 32'(e_prot));
    check({tag, " R5 paddr"}, rsp_paddr, e_pa);
    check({tag, " R6 sel"}, sel_reg, m_sel);
    check({tag, " R7 cause"}, cause_reg, m_cause);
  endtask

  task automatic t_reset;
    check("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R11 sel after reset", sel_reg, 32'd0);
    check("R11 cause after reset", cause_reg, 32'd0);
  endtask

  task automatic t_basic;
    put(1, 0, 4'h3, mk_hi(19'h00123, 8'h42), mk_lo(19'h7ABCD, 0, 1, 0, 1, 0));
    lookup("R1 owner match read", {19'h00123, 13'h1F0F}, 2'd0, 0, 0, 8'h42, 32'h0, 1, 4'd8);
    check("R5 paddr value", rsp_paddr, {19'h7ABCD, 13'h1F0F});
    check("R5 prot rw", 32'(rsp_prot), 32'h3);
    lookup("R1 owner mismatch", {19'h00123, 13'h0004}, 2'd0, 0, 0, 8'h43, 32'h0, 0, 4'd8);
    check("R6 first refill way from seed", 32'(sel_reg[5:4]), 32'd0);
    check("R7 cause read code", 32'(cause_reg[9:8]), 32'd1);
    put(1, 1, 4'h7, mk_hi(19'h04567, 8'h01), mk_lo(19'h00055, 1, 1, 0, 0, 0));
    lookup("R1 global overrides owner", {19'h04567, 13'h0100}, 2'd1, 1, 0, 8'h99, 32'h0, 1, 4'd8);
    check("R5 no write perm", 32'(rsp_prot), 32'h1);
  endtask

  task automatic t_lowest_way;
    put(1, 3, 4'h9, mk_hi(19'h00019, 8'h05), mk_lo(19'h33333, 0, 1, 0, 1, 0));
    put(1, 1, 4'h9, mk_hi(19'h00019, 8'h05), mk_lo(19'h11111, 0, 1, 0, 0, 0));
    lookup("R2 lowest way wins", {19'h00019, 13'h0000}, 2'd0, 0, 0, 8'h05, 32'h0, 1, 4'd8);
    check("R2 frame of way1", 32'(rsp_paddr[31:13]), 32'h11111);
  endtask

  task automatic t_sides;
    put(1, 0, 4'hA, mk_hi(19'h0002A, 8'h07), mk_lo(19'h0AAAA, 0, 1, 0, 0, 1));
    lookup("R3 exec ignores data table", {19'h0002A, 13'h0010}, 2'd2, 0, 0, 8'h07, 32'h0, 0, 4'd4);
    check("R7 cause exec code", 32'(cause_reg[9:8]), 32'd0);
    put(0, 2, 4'hA, mk_hi(19'h0002A, 8'h07), mk_lo(19'h0BBBB, 0, 1, 0, 0, 1));
    lookup("R3 exec in insn table", {19'h0002A, 13'h0010}, 2'd2, 0, 0, 8'h07, 32'h0, 1, 4'd4);
    check("R5 exec perm", 32'(rsp_prot), 32'h5);
    lookup("R3 read uses data table", {19'h0002A, 13'h0010}, 2'd0, 0, 0, 8'h07, 32'h0, 1, 4'd8);
    check("R3 data frame", 32'(rsp_paddr[31:13]), 32'h0AAAA);
    lookup("R3 kind 3 as read", {19'h0002A, 13'h0010}, 2'd3, 0, 0, 8'h07, 32'h0, 1, 4'd8);
  endtask

  task automatic t_faults;
    put(1, 2, 4'h5, mk_hi(19'h00025, 8'h11), mk_lo(19'h12345, 0, 0, 1, 0, 0));
    lookup("R4 kernel in user first", {19'h00025, 13'h0ABC}, 2'd1, 1, 0, 8'h11, 32'h000F0000, 0, 4'd10);
    check("R6 fault reports matched way", 32'(sel_reg[5:0]), 32'h25);
    lookup("R4 write protect", {19'h00025, 13'h0ABC}, 2'd1, 0, 0, 8'h11, 32'h000F0000, 0, 4'd11);
    check("R7 cause write code", 32'(cause_reg[9:8]), 32'd2);
    lookup("R4 invalid", {19'h00025, 13'h0ABC}, 2'd0, 0, 0, 8'h11, 32'h00010000, 0, 4'd9);
    lookup("R4 checks disabled", {19'h00025, 13'h0ABC}, 2'd0, 1, 0, 8'h11, 32'h0, 1, 4'd8);
    put(0, 1, 4'h5, mk_hi(19'h00025, 8'h11), mk_lo(19'h54321, 0, 0, 0, 0, 0));
    lookup("R4 exec protect before invalid", {19'h00025, 13'h0001}, 2'd2, 0, 0, 8'h11, 32'h00030000, 0, 4'd7);
    check("R6 insn fault way", 32'(sel_reg[5:4]), 32'd1);
    lookup("R5 exec perm off", {19'h00025, 13'h0001}, 2'd2, 0, 0, 8'h11, 32'h0, 1, 4'd4);
    check("R5 read only", 32'(rsp_prot), 32'h1);
    lookup("R5 exec perm via cfg", {19'h00025, 13'h0001}, 2'd2, 0, 0, 8'h11, 32'h00020000, 0, 4'd7);
  endtask

  task automatic t_lfsr_debug;
    logic [31:0] s0, c0;
    for (int i = 0; i < 6; i++) begin
      lookup("R8 refill sequence", {19'h40000 + 19'(i), 13'h0}, 2'd0, 0, 0, 8'h3C, 32'h0, 0, 4'd8);
    end
    s0 = sel_reg; c0 = cause_reg;
    lookup("R9 debug miss", {19'h5000F, 13'h0}, 2'd1, 0, 1, 8'hF0, 32'h0, 0, 4'd8);
    check("R9 sel unchanged", sel_reg, s0);
    check("R9 cause unchanged", cause_reg, c0);
    lookup("R9 lfsr not stepped", {19'h5000E, 13'h0}, 2'd0, 0, 0, 8'hF0, 32'h0, 0, 4'd8);
  endtask

  task automatic t_write_timing;
    pw_en = 1'b1; pw_side = 1; pw_way = 2'd3; pw_slot = 4'hC;
    pw_hi = mk_hi(19'h0003C, 8'h21); pw_lo = mk_lo(19'h0CCCC, 0, 1, 0, 1, 0);
    lookup("R10 same-cycle write unseen", {19'h0003C, 13'h0}, 2'd0, 0, 0, 8'h21, 32'h0, 0, 4'd8);
    lookup("R10 write seen next cycle", {19'h0003C, 13'h0}, 2'd0, 0, 0, 8'h21, 32'h0, 1, 4'd8);
    @(negedge clk);
    check("R10 valid single cycle", 32'(rsp_valid), 32'd0);
    check("R10 hit held", 32'(rsp_hit), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_vaddr = 0; req_kind = 0; req_user = 0;
    req_debug = 0; req_pid = 0; req_cfg = 0; wr_en = 0; wr_side = 0;
    wr_way = 0; wr_slot = 0; wr_hi = 0; wr_lo = 0;
    m_lfsr = 16'hCCCC; m_sel = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        for (int k = 0; k < 16; k++)
          put(1'(s), 2'(w), 4'(k), mk_hi(19'h7FFFF, 8'hEE), 32'h0);
    t_basic();
    t_lowest_way();
    t_sides();
    t_faults();
    t_lfsr_debug();
    t_write_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule